// File: doc/BRIEF.md
# Multi-Class Weighted Queue Arbiter

This block decides, once per clock, which of a set of submission queues supplies the next command. Each queue presents a request line and a three-bit class tag. Two strict tiers sit on top: an admin class and an urgent class. Below them, three weighted classes (high, medium, low) share what bandwidth remains in proportion to per-class weights. Inside every class, the queues that are asking are served in rotating order, so that no queue in a class can starve a sibling.

The weighted stage keeps one credit counter for each weighted class. When a class wins, its counter goes down by one. When no pending weighted class has credit left, all three counters are refilled from their weights, so a full round grants each busy class as many times as its weight. A mode input can switch the tiers off. The block then treats every queue as an equal in one rotation. Weights and class tags are static inputs. The grant is registered and appears one cycle after the requests it was computed from.

Top module: `wrr_queue_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, grant_valid is 0 and grant_idx and grant_onehot are all zeros. All rotation pointers and all credits start at zero.
- R2: If no request is asserted in a cycle, grant_valid is 0 in the next cycle, and grant_idx and grant_onehot are zero.
- R3: With tiers enabled (prio_en=1), a requesting queue tagged admin (code 0) is always granted ahead of every other class.
- R4: With tiers enabled, a requesting queue tagged urgent (code 1) is granted only when no admin request is pending, and it is always granted ahead of the weighted classes.
- R5: Within one class, the search starts at that class's pointer and goes upward with wrap. After a grant in that class, the pointer moves to the queue after the granted one. It moves only when that class wins.
- R6: The weighted classes are high (code 2), medium (code 3) and low (code 4). The winner is the first class in the order high, medium, low that has a request and a nonzero credit. The winner's credit drops by one. When no requesting weighted class has credit, all three credits are reloaded from the weights before the choice is made.
- R7: A weighted class with no request is skipped, and its credit stays unchanged.
- R8: A weight of 0 behaves exactly like a weight of 1.
- R9: With prio_en=0, class tags and credits are ignored. All requesting queues share one rotation with its own pointer, which moves past each granted queue.
- R10: A grant appears the cycle after the requests it answers. It always names a queue that was requesting in that cycle, and grant_onehot has exactly the bit grant_idx set.
- R11: Tag codes 5, 6 and 7 are treated as the low class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prio_en | input | 1 | 1: class tiers and weights active; 0: plain rotation over all queues |
| req | input | NUM_Q | One request bit per queue |
| class_tag | input | 3*NUM_Q | Class code of queue q in bits [3q+2:3q] |
| weight_high | input | WW | Weight of the high class |
| weight_med | input | WW | Weight of the medium class |
| weight_low | input | WW | Weight of the low class |
| grant_valid | output | 1 | A grant is issued this cycle |
| grant_idx | output | log2(NUM_Q) | Index of the granted queue, zero when idle |
| grant_onehot | output | NUM_Q | One-hot form of the grant, zero when idle |

## Verification
The bench goes after credit reloads that land in the same cycle as a grant. A design that reloads one cycle late would insert a spurious idle cycle or hand the round to the wrong class. A weighted class that falls silent for a while and then returns must keep its unused credit; a design that spends or clears it would shift the grant ratio. Admin and urgent bursts interleaved with weighted traffic test that a class's pointer holds still while another class wins, since a pointer that moves on every grant breaks fairness inside the class. Zero weights, out-of-range tag codes, pointer wrap from the top queue and switches into and out of flat mode each have their own phase, because a slip in any of them changes the granted index.

// File: rtl/wrr_arb_pkg.sv
package wrr_arb_pkg;

    localparam int NUM_CLS   = 5;
    localparam int TAG_W     = 3;
    localparam int NUM_WCLS  = 3;

    localparam logic [TAG_W-1:0] CLS_ADMIN  = 3'd0;
    localparam logic [TAG_W-1:0] CLS_URGENT = 3'd1;
    localparam logic [TAG_W-1:0] CLS_HIGH   = 3'd2;
    localparam logic [TAG_W-1:0] CLS_LOW    = 3'd4;

    // Codes above the low class fold onto it.
    function automatic logic [TAG_W-1:0] class_of(logic [TAG_W-1:0] tag);
        return (tag > CLS_LOW) ? CLS_LOW : tag;
    endfunction

endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin : scan
        int p;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            p = (int'(start) + k) % N;
            if (!found && mask[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end

endmodule

// File: rtl/wrr_class_sel.sv
module wrr_class_sel #(
    parameter int WW = 8
) (
    input  logic [2:0]         pend,
    input  logic [2:0][WW-1:0] weight,
    input  logic [2:0][WW-1:0] credit_q,
    output logic               win_found,
    output logic [1:0]         win_cls,
    output logic [2:0][WW-1:0] credit_d
);

    logic [2:0][WW-1:0] eff_w;
    logic [2:0][WW-1:0] cur;
    logic [2:0]         elig;
    logic               reload;

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            eff_w[k] = (weight[k] == '0) ? WW'(1) : weight[k];
            elig[k]  = pend[k] && (credit_q[k] != '0);
        end
        reload    = (|pend) && !(|elig);
        cur       = reload ? eff_w : credit_q;
        win_found = 1'b0;
        win_cls   = 2'd0;
        for (int k = 0; k < 3; k++) begin
            if (!win_found && pend[k] && (cur[k] != '0)) begin
                win_found = 1'b1;
                win_cls   = 2'(k);
            end
        end
        credit_d = cur;
        if (win_found) credit_d[win_cls] = cur[win_cls] - WW'(1);
    end

endmodule

// File: rtl/wrr_queue_arbiter.sv
module wrr_queue_arbiter
    import wrr_arb_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int WW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   prio_en,
    input  logic [NUM_Q-1:0]       req,
    input  logic [NUM_Q*TAG_W-1:0] class_tag,
    input  logic [WW-1:0]          weight_high,
    input  logic [WW-1:0]          weight_med,
    input  logic [WW-1:0]          weight_low,
    output logic                   grant_valid,
    output logic [$clog2(NUM_Q)-1:0] grant_idx,
    output logic [NUM_Q-1:0]       grant_onehot
);

    localparam int IW = $clog2(NUM_Q);

    typedef struct packed {
        logic [NUM_CLS-1:0][IW-1:0]  ptr;
        logic [IW-1:0]               flat_ptr;
        logic [NUM_WCLS-1:0][WW-1:0] credit;
        logic                        valid;
        logic [IW-1:0]               idx;
    } arb_state_t;

    arb_state_t s_d, s_q;

    logic [NUM_CLS-1:0][NUM_Q-1:0] cls_mask;
    logic [NUM_CLS-1:0]            cls_found;
    logic [NUM_CLS-1:0][IW-1:0]    cls_idx;
    logic                          flat_found;
    logic [IW-1:0]                 flat_idx;
    logic [NUM_WCLS-1:0][WW-1:0]   wvec;
    logic                          w_found;
    logic [1:0]                    w_cls;
    logic [NUM_WCLS-1:0][WW-1:0]   w_credit_d;

    function automatic logic [IW-1:0] after(logic [IW-1:0] i);
        return (int'(i) == NUM_Q - 1) ? '0 : i + IW'(1);
    endfunction

    // Per-queue class decode
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic [TAG_W-1:0] cq;
        assign cq = class_of(class_tag[q*TAG_W +: TAG_W]);
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_c
            assign cls_mask[c][q] = req[q] && (cq == TAG_W'(c));
        end
    end

    // One rotating picker per class
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_pick
        rr_pick #(.N(NUM_Q), .IW(IW)) u_pick (
            .mask  (cls_mask[c]),
            .start (s_q.ptr[c]),
            .found (cls_found[c]),
            .idx   (cls_idx[c])
        );
    end

    rr_pick #(.N(NUM_Q), .IW(IW)) u_flat (
        .mask  (req),
        .start (s_q.flat_ptr),
        .found (flat_found),
        .idx   (flat_idx)
    );

    assign wvec = {weight_low, weight_med, weight_high};

    wrr_class_sel #(.WW(WW)) u_wsel (
        .pend      (cls_found[NUM_CLS-1:2]),
        .weight    (wvec),
        .credit_q  (s_q.credit),
        .win_found (w_found),
        .win_cls   (w_cls),
        .credit_d  (w_credit_d)
    );

    always_comb begin
        int wc;
        wc        = 2 + int'(w_cls);
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.idx   = '0;
        if (!prio_en) begin
            if (flat_found) begin
                s_d.valid    = 1'b1;
                s_d.idx      = flat_idx;
                s_d.flat_ptr = after(flat_idx);
            end
        end else if (cls_found[CLS_ADMIN]) begin
            s_d.valid             = 1'b1;
            s_d.idx               = cls_idx[CLS_ADMIN];
            s_d.ptr[CLS_ADMIN]    = after(cls_idx[CLS_ADMIN]);
        end else if (cls_found[CLS_URGENT]) begin
            s_d.valid             = 1'b1;
            s_d.idx               = cls_idx[CLS_URGENT];
            s_d.ptr[CLS_URGENT]   = after(cls_idx[CLS_URGENT]);
        end else if (w_found) begin
            s_d.valid   = 1'b1;
            s_d.idx     = cls_idx[wc];
            s_d.ptr[wc] = after(cls_idx[wc]);
            s_d.credit  = w_credit_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant_valid  = s_q.valid;
    assign grant_idx    = s_q.idx;
    assign grant_onehot = s_q.valid ? (NUM_Q'(1) << s_q.idx) : '0;

    // R10
    onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant_onehot) == 1));

    // R10
    granted_was_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (($past(req) & grant_onehot) != '0));

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> !grant_valid);

    // R3
    admin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_en && (cls_mask[CLS_ADMIN] != '0))
        |=> (($past(cls_mask[CLS_ADMIN]) & grant_onehot) != '0));

    // R4
    urgent_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_en && (cls_mask[CLS_ADMIN] == '0) && (cls_mask[CLS_URGENT] != '0))
        |=> (($past(cls_mask[CLS_URGENT]) & grant_onehot) != '0));

    // R9
    flat_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_en && (req != '0)) |=> grant_valid);

endmodule

// File: tb/tb_wrr_queue_arbiter.sv
module tb_wrr_queue_arbiter;

    localparam int NQ = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prio_en = 1'b1;
    logic [15:0] req = '0;
    logic [47:0] tags = '0;
    logic [7:0]  wh = 8'd1, wm = 8'd1, wl = 8'd1;
    logic        grant_valid;
    logic [3:0]  grant_idx;
    logic [15:0] grant_onehot;

    int checks = 0;
    int errors = 0;

    int m_ptr[5];
    int m_flat;
    int m_cred[3];
    bit e_valid;
    int e_idx;

    always #10 clk = ~clk;

    wrr_queue_arbiter dut (
        .clk(clk), .rst_n(rst_n), .prio_en(prio_en), .req(req),
        .class_tag(tags), .weight_high(wh), .weight_med(wm), .weight_low(wl),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_onehot(grant_onehot)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cls_of(int q);
        int t;
        t = int'(tags[q*3 +: 3]);
        return (t > 4) ? 4 : t;
    endfunction

    function automatic int pick(int cls, int start);
        for (int k = 0; k < NQ; k++) begin
            int q;
            q = (start + k) % NQ;
            if (req[q] && (cls < 0 || cls_of(q) == cls)) return q;
        end
        return -1;
    endfunction

    function automatic int effw(logic [7:0] w);
        return (w == 0) ? 1 : int'(w);
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 5; c++) m_ptr[c] = 0;
        for (int c = 0; c < 3; c++) m_cred[c] = 0;
        m_flat = 0;
    endtask

    task automatic model_eval();
        int g;
        int pend[3];
        int anyel;
        int anyp;
        int win;
        e_valid = 0;
        e_idx   = 0;
        if (req == '0) return;
        if (!prio_en) begin
            g = pick(-1, m_flat);
            m_flat = (g + 1) % NQ;
            e_valid = 1; e_idx = g;
            return;
        end
        for (int c = 0; c < 2; c++) begin
            g = pick(c, m_ptr[c]);
            if (g >= 0) begin
                m_ptr[c] = (g + 1) % NQ;
                e_valid = 1; e_idx = g;
                return;
            end
        end
        anyel = 0; anyp = 0;
        for (int c = 0; c < 3; c++) begin
            pend[c] = (pick(c + 2, 0) >= 0) ? 1 : 0;
            if (pend[c] != 0) anyp = 1;
            if (pend[c] != 0 && m_cred[c] > 0) anyel = 1;
        end
        if (anyp == 0) return;
        if (anyel == 0) begin
            m_cred[0] = effw(wh); m_cred[1] = effw(wm); m_cred[2] = effw(wl);
        end
        win = -1;
        for (int c = 0; c < 3; c++)
            if (win < 0 && pend[c] != 0 && m_cred[c] > 0) win = c;
        m_cred[win]--;
        g = pick(win + 2, m_ptr[win + 2]);
        m_ptr[win + 2] = (g + 1) % NQ;
        e_valid = 1; e_idx = g;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) begin
            model_eval();
            @(negedge clk);
            chk(grant_valid == e_valid && int'(grant_idx) == e_idx, tag,
                {grant_valid, grant_idx}, {e_valid, 4'(e_idx)});
            chk(grant_onehot == (e_valid ? (16'd1 << e_idx) : 16'd0), "R10 onehot",
                int'(grant_onehot), e_valid ? (1 << e_idx) : 0);
        end
    endtask

    task automatic set_cls(int q, int c);
        tags[q*3 +: 3] = 3'(c);
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        for (int q = 0; q < NQ; q++) set_cls(q, 4);
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk(grant_valid == 0 && grant_idx == 0 && grant_onehot == 0, "R1 in reset",
            {grant_valid, grant_idx}, 0);
        req = 16'hFFFF;
        @(negedge clk);
        chk(grant_valid == 0 && grant_onehot == 0, "R1 in reset with req",
            int'(grant_onehot), 0);
        req = '0;
        rst_n = 1'b1;
        run(4, "R2 idle");

        // R3: admin beats everything
        set_cls(3, 0); set_cls(9, 0); set_cls(5, 1); set_cls(0, 2); set_cls(2, 3);
        req = 16'b0000_0010_0010_1101;
        run(8, "R3 admin");
        // R4: urgent once admin drops
        req[3] = 0; req[9] = 0; set_cls(12, 1); req[12] = 1;
        run(8, "R4 urgent");

        // R6 and R5: weighted share, two queues per class
        req = '0;
        for (int q = 0; q < NQ; q++) set_cls(q, 4);
        set_cls(0, 2); set_cls(1, 2); set_cls(2, 3); set_cls(7, 3); set_cls(4, 4); set_cls(15, 4);
        wh = 8'd2; wm = 8'd3; wl = 8'd1;
        req = 16'b1000_0000_1001_0111;
        run(36, "R6 weighted share");
        req = 16'h0003;
        run(5, "R5 rotation in class");
        // R5: admin burst does not move weighted pointers
        set_cls(6, 0); req[6] = 1; req[2] = 1;
        run(3, "R5 pointer holds");
        req[6] = 0;
        run(10, "R5 after burst");

        // R7: medium silent, keeps its credit
        wh = 8'd2; wm = 8'd2; wl = 8'd2;
        req = 16'h0011;
        run(7, "R7 skip idle class");
        req[2] = 1;
        run(12, "R7 class returns");

        // R8: zero weights act as one
        wh = 8'd0; wm = 8'd0; wl = 8'd3;
        req = 16'b1000_0000_1001_0111;
        run(20, "R8 zero weight");

        // R11: codes 5..7 fold into low
        req = '0;
        for (int q = 0; q < NQ; q++) set_cls(q, 4);
        set_cls(8, 7); set_cls(10, 5); set_cls(11, 6); set_cls(13, 2);
        wh = 8'd1; wm = 8'd1; wl = 8'd2;
        req = 16'b0010_1101_0000_0000;
        run(16, "R11 high codes");

        // R9: flat rotation ignores tiers
        prio_en = 1'b0;
        set_cls(3, 0); set_cls(5, 1);
        req = 16'b1000_0000_0010_1001;
        run(12, "R9 flat mode");
        req = 16'h8000;
        run(2, "R9 flat wrap");
        req = 16'h0001;
        run(2, "R9 flat wrap");
        prio_en = 1'b1;
        req = 16'h0028;
        run(4, "R9 back to tiers");
        req = '0;
        run(2, "R2 idle again");

        // R10: random traffic
        for (int i = 0; i < 600; i++) begin
            if (i % 50 == 0) begin
                for (int q = 0; q < NQ; q++) set_cls(q, int'($urandom_range(0, 7)));
                wh = 8'($urandom_range(0, 4));
                wm = 8'($urandom_range(0, 4));
                wl = 8'($urandom_range(0, 4));
                prio_en = ($urandom_range(0, 4) != 0);
            end
            req = 16'($urandom) & 16'($urandom);
            if (i % 9 == 0) req = '0;
            run(1, "R10 random traffic");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule